// File: doc/BRIEF.md
# Interface Adapter Timer and Interrupt Core

This block is a small memory-mapped peripheral with sixteen register slots. A host reaches it through a 4-bit register select, an 8-bit write bus, a registered 8-bit read bus, a chip select and a direction strobe. It holds two 8-bit output ports, each paired with a direction register. It has two one-shot down-counters: a 16-bit timer with a 16-bit reload latch, and a 16-bit timer that is loaded from a low-byte latch plus the byte written to start it. It also holds a 7-bit interrupt flag set, a 7-bit interrupt mask and an active-low interrupt request.

Software starts a count by writing the timer's start register. The counter then drops by one on every clock until it reaches zero. At zero it raises its flag and halts until it is reloaded. The flag is removed by writing a one to it, by reading the timer's low counter byte, or by starting the timer again. The mask is changed with a set/clear protocol chosen by bit 7 of the written byte. The request output goes low when a flag and its mask bit are both set.

Top module: `via_core`

## Requirements
- R1: After reset every register, both counters, all flags and all mask bits are zero, both timers are stopped, `irq_n` is 1 and `rdata` is 0.
- R2: Offsets 0 and 2 hold the port-B output and direction bytes; offsets 1 and 3 hold the port-A output and direction bytes. Each reads back what was written and appears on its output pins from the clock after the write.
- R3: Writing offset 4 stores the timer-1 latch low byte and loads the counter with {latch high, written byte}. It does not start or stop the timer. Writes to offsets 6 and 7 change only the latch low and high bytes and leave the counter unchanged.
- R4: Writing offset 5 stores the latch high byte, loads the counter with {written byte, latch low}, starts timer 1 and clears flag bit 6.
- R5: A running timer with a nonzero count drops by exactly one per clock. On the clock where it reaches zero, timer 1 sets flag bit 6 and stops, and the count then stays at zero. Offsets 4 and 5 read the low and high counter bytes.
- R6: Writing offset 8 stores the timer-2 low latch, which offset 9 reads back. Writing offset 9 loads the timer-2 counter with {written byte, low latch}, clears flag bit 5 and starts timer 2. On reaching zero timer 2 sets flag bit 5 and stops. Offset 8 reads the counter low byte.
- R7: Reading offset 4 clears flag bit 6, and reading offset 8 clears flag bit 5. The read returns the value the register held before the access.
- R8: Offset 13 reads the flags in bits 6..0, and bit 7 reads as 1 exactly when some flag and its mask bit are both set. Writing offset 13 clears each flag whose written bit is 1 and leaves the other flags unchanged.
- R9: Writing offset 14 with bit 7 set ORs bits 6..0 into the mask. With bit 7 clear, it clears each mask bit written as 1. Reading offset 14 returns the mask with bit 7 forced to 1.
- R10: `irq_n` is registered. It goes low one clock after a flag and its mask bit are both set, and returns high one clock after no such pair remains.
- R11: Offsets 10, 11, 12 and 15 read as 0, and writes to them change no register.
- R12: A read drives `rdata` on the clock after the select, and `rdata` holds until the next read. If a timer reaches zero on the same clock as a clear of its flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Access select for this clock |
| we | input | 1 | 1 = write, 0 = read when `cs` is high |
| addr | input | 4 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |
| pa_out | output | 8 | Port-A output register |
| pa_dir | output | 8 | Port-A direction register |
| pb_out | output | 8 | Port-B output register |
| pb_dir | output | 8 | Port-B direction register |

## Verification
The hardest case to reach is a flag clear landing on the very clock where a timer reaches zero, because both events must meet on one edge. The bench counts the edges from the start write: a counter loaded with N at edge E reaches zero at edge E+N. It then places a flag-clear write exactly on that edge and reads the flag back. The same edge counting is used to sample the decrement rate mid-count, and to catch `irq_n` staying high on the edge where the flag rises and falling one clock later.

// File: rtl/via_pkg.sv
package via_pkg;
  localparam int ADDR_W = 4;
  localparam int NREG   = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] OFS_PB_OUT  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_PA_OUT  = 4'h1;
  localparam logic [ADDR_W-1:0] OFS_PB_DIR  = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_PA_DIR  = 4'h3;
  localparam logic [ADDR_W-1:0] OFS_T1_CLO  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_T1_CHI  = 4'h5;
  localparam logic [ADDR_W-1:0] OFS_T1_LLO  = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_T1_LHI  = 4'h7;
  localparam logic [ADDR_W-1:0] OFS_T2_CLO  = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_T2_GO   = 4'h9;
  localparam logic [ADDR_W-1:0] OFS_FLAGS   = 4'hD;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 4'hE;

  localparam int FLAG_T1 = 6;
  localparam int FLAG_T2 = 5;
endpackage

// File: rtl/via_port.sv
module via_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          out_we,
  input  logic          dir_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (out_we) out_q <= wdata;
      if (dir_we) dir_q <= wdata;
    end
  end
endmodule

// File: rtl/via_timer.sv
module via_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          start,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          run,
  output logic          expire
);
  localparam logic [CW-1:0] ONE = CW'(1);

  // one-shot: the step that lands on zero raises expire and halts
  assign expire = run && (cnt == ONE) && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else begin
      if (load)
        cnt <= load_val;
      else if (run && cnt != '0)
        cnt <= cnt - ONE;

      if (load && start)
        run <= 1'b1;
      else if (expire)
        run <= 1'b0;
    end
  end
endmodule

// File: rtl/via_irq.sv
module via_irq #(
  parameter int DW = 8,
  localparam int NF = DW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_vec,
  input  logic [NF-1:0] clr_vec,
  input  logic          mask_we,
  input  logic [DW-1:0] mask_data,
  output logic [NF-1:0] ifr_q,
  output logic [NF-1:0] ier_q,
  output logic          pending,
  output logic          irq_n
);
  assign pending = |(ifr_q & ier_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ifr_q <= '0;
      ier_q <= '0;
      irq_n <= 1'b1;
    end else begin
      // a new event outranks a clear in the same clock
      ifr_q <= (ifr_q & ~clr_vec) | set_vec;
      if (mask_we) begin
        if (mask_data[DW-1])
          ier_q <= ier_q | mask_data[NF-1:0];
        else
          ier_q <= ier_q & ~mask_data[NF-1:0];
      end
      irq_n <= ~pending;
    end
  end
endmodule

// File: rtl/via_core.sv
module via_core
  import via_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq_n,
  output logic [DW-1:0]     pa_out,
  output logic [DW-1:0]     pa_dir,
  output logic [DW-1:0]     pb_out,
  output logic [DW-1:0]     pb_dir
);
  localparam int CW = 2 * DW;
  localparam int NF = DW - 1;
  localparam int NPORT = 2;

  logic [NREG-1:0] wsel, rsel;
  assign wsel = (cs && we)  ? (NREG'(1) << addr) : '0;
  assign rsel = (cs && !we) ? (NREG'(1) << addr) : '0;

  // ports: index 0 = B, index 1 = A; output at offset i, direction at i+2
  logic [DW-1:0] p_out [NPORT];
  logic [DW-1:0] p_dir [NPORT];
  for (genvar i = 0; i < NPORT; i++) begin : g_port
    via_port #(.DW(DW)) u_port (
      .clk   (clk),
      .rst   (rst),
      .out_we(wsel[i]),
      .dir_we(wsel[i+2]),
      .wdata (wdata),
      .out_q (p_out[i]),
      .dir_q (p_dir[i])
    );
  end
  assign pb_out = p_out[0];
  assign pb_dir = p_dir[0];
  assign pa_out = p_out[1];
  assign pa_dir = p_dir[1];

  // timer-1 reload latch
  logic [DW-1:0] t1_lat_lo, t1_lat_hi, t2_lat_lo;
  always_ff @(posedge clk) begin
    if (rst) begin
      t1_lat_lo <= '0;
      t1_lat_hi <= '0;
      t2_lat_lo <= '0;
    end else begin
      if (wsel[OFS_T1_CLO] || wsel[OFS_T1_LLO]) t1_lat_lo <= wdata;
      if (wsel[OFS_T1_CHI] || wsel[OFS_T1_LHI]) t1_lat_hi <= wdata;
      if (wsel[OFS_T2_CLO])                      t2_lat_lo <= wdata;
    end
  end

  logic          t1_load, t1_start, t1_run, t1_exp;
  logic          t2_load, t2_start, t2_run, t2_exp;
  logic [CW-1:0] t1_val, t2_val, t1_cnt, t2_cnt;

  assign t1_load  = wsel[OFS_T1_CLO] || wsel[OFS_T1_CHI];
  assign t1_start = wsel[OFS_T1_CHI];
  assign t1_val   = wsel[OFS_T1_CHI] ? {wdata, t1_lat_lo} : {t1_lat_hi, wdata};
  assign t2_load  = wsel[OFS_T2_GO];
  assign t2_start = wsel[OFS_T2_GO];
  assign t2_val   = {wdata, t2_lat_lo};

  via_timer #(.CW(CW)) u_t1 (
    .clk(clk), .rst(rst), .load(t1_load), .start(t1_start),
    .load_val(t1_val), .cnt(t1_cnt), .run(t1_run), .expire(t1_exp)
  );

  via_timer #(.CW(CW)) u_t2 (
    .clk(clk), .rst(rst), .load(t2_load), .start(t2_start),
    .load_val(t2_val), .cnt(t2_cnt), .run(t2_run), .expire(t2_exp)
  );

  // interrupt flags and mask
  logic [NF-1:0] set_vec, clr_vec, ifr_q, ier_q;
  logic          pending;

  always_comb begin
    set_vec = '0;
    set_vec[FLAG_T1] = t1_exp;
    set_vec[FLAG_T2] = t2_exp;
    clr_vec = wsel[OFS_FLAGS] ? wdata[NF-1:0] : '0;
    if (rsel[OFS_T1_CLO] || wsel[OFS_T1_CHI]) clr_vec[FLAG_T1] = 1'b1;
    if (rsel[OFS_T2_CLO] || wsel[OFS_T2_GO])  clr_vec[FLAG_T2] = 1'b1;
  end

  via_irq #(.DW(DW)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .mask_we  (wsel[OFS_MASK]),
    .mask_data(wdata),
    .ifr_q    (ifr_q),
    .ier_q    (ier_q),
    .pending  (pending),
    .irq_n    (irq_n)
  );

  // read path, registered
  logic [DW-1:0] rmux;
  always_comb begin
    case (addr)
      OFS_PB_OUT: rmux = p_out[0];
      OFS_PA_OUT: rmux = p_out[1];
      OFS_PB_DIR: rmux = p_dir[0];
      OFS_PA_DIR: rmux = p_dir[1];
      OFS_T1_CLO: rmux = t1_cnt[DW-1:0];
      OFS_T1_CHI: rmux = t1_cnt[CW-1:DW];
      OFS_T1_LLO: rmux = t1_lat_lo;
      OFS_T1_LHI: rmux = t1_lat_hi;
      OFS_T2_CLO: rmux = t2_cnt[DW-1:0];
      OFS_T2_GO:  rmux = t2_lat_lo;
      OFS_FLAGS:  rmux = {pending, ifr_q};
      OFS_MASK:   rmux = {1'b1, ier_q};
      default:    rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            rdata <= '0;
    else if (cs && !we) rdata <= rmux;
  end
endmodule

// File: rtl/via_core_chk.sv
module via_core_chk #(
  parameter int DW = 8,
  localparam int CW = 2 * DW,
  localparam int NF = DW - 1
) (
  input logic          clk,
  input logic          rst,
  input logic          cs,
  input logic          we,
  input logic [3:0]    addr,
  input logic [DW-1:0] rdata,
  input logic          irq_n,
  input logic [NF-1:0] ifr_q,
  input logic [NF-1:0] ier_q,
  input logic [CW-1:0] t1_cnt,
  input logic          t1_run,
  input logic [CW-1:0] t2_cnt,
  input logic          t2_run
);
  localparam logic [CW-1:0] ONE = CW'(1);
  logic t1_wr, t2_wr, rd, gap;
  assign t1_wr = cs && we && (addr == 4'h4 || addr == 4'h5);
  assign t2_wr = cs && we && (addr == 4'h9);
  assign rd    = cs && !we;
  assign gap   = addr == 4'hA || addr == 4'hB || addr == 4'hC || addr == 4'hF;

  AST_T1_STEP: assert property (@(posedge clk) disable iff (rst)
    (t1_run && t1_cnt != '0 && !t1_wr) |=> (t1_cnt == $past(t1_cnt) - ONE)); // R5
  AST_T1_FLAG: assert property (@(posedge clk) disable iff (rst)
    (t1_run && t1_cnt == ONE && !t1_wr) |=> (ifr_q[6] && !t1_run)); // R5
  AST_T1_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!t1_run && !t1_wr) |=> $stable(t1_cnt)); // R3
  AST_T2_FLAG: assert property (@(posedge clk) disable iff (rst)
    (t2_run && t2_cnt == ONE && !t2_wr) |=> (ifr_q[5] && !t2_run)); // R6
  AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n == !$past(|(ifr_q & ier_q)))); // R10
  AST_MASK_TOP: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == 4'hE) |=> rdata[DW-1]); // R9
  AST_GAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd && gap) |=> (rdata == '0)); // R11
endmodule

bind via_core via_core_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .rdata(rdata),
  .irq_n(irq_n), .ifr_q(ifr_q), .ier_q(ier_q),
  .t1_cnt(t1_cnt), .t1_run(t1_run), .t2_cnt(t2_cnt), .t2_run(t2_run)
);

// File: tb/via_core_test.sv
`timescale 1ns/1ps
module via_core_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, pa_out, pa_dir, pb_out, pb_dir;
  logic       irq_n;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  via_core uut (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_n(irq_n), .pa_out(pa_out), .pa_dir(pa_dir),
    .pb_out(pb_out), .pb_dir(pb_dir)
  );

  // tasks are entered on a falling edge and return on the next one
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sbq.push_back(it);
    cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic idle(input int n);
    cs = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] e, input string tag);
    compared++;
    if (act !== e) begin
      mismatched++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, e);
    end
  endtask

  // monitor: compares each read result against the queued expectation
  initial begin
    bit issued;
    forever begin
      @(posedge clk);
      issued = cs && !we && !rst;
      @(negedge clk);
      if (issued) begin
        item_t it;
        compared++;
        if (sbq.size() == 0) begin
          mismatched++;
          $display("FAIL unexpected-read actual=%02h expected=none", rdata);
        end else begin
          it = sbq.pop_front();
          if (rdata !== it.exp) begin
            mismatched++;
            $display("FAIL %s actual=%02h expected=%02h", it.tag, rdata, it.exp);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk({7'b0, irq_n}, 8'h01, "R1 irq_n");
    chk(rdata, 8'h00, "R1 rdata");
    chk(pa_out | pa_dir | pb_out | pb_dir, 8'h00, "R1 ports");
    rd(4'hE, 8'h80, "R1 mask");
    rd(4'hD, 8'h00, "R1 flags");
    rd(4'h4, 8'h00, "R1 t1 count");

    // R2 port registers
    wr(4'h0, 8'hA5); wr(4'h1, 8'h3C); wr(4'h2, 8'hF0); wr(4'h3, 8'h0F);
    chk(pb_out, 8'hA5, "R2 pb_out"); chk(pa_out, 8'h3C, "R2 pa_out");
    chk(pb_dir, 8'hF0, "R2 pb_dir"); chk(pa_dir, 8'h0F, "R2 pa_dir");
    rd(4'h0, 8'hA5, "R2 rd0"); rd(4'h1, 8'h3C, "R2 rd1");
    rd(4'h2, 8'hF0, "R2 rd2"); rd(4'h3, 8'h0F, "R2 rd3");

    // R11 unused offsets
    wr(4'hA, 8'hFF); wr(4'hF, 8'hFF); wr(4'hC, 8'hFF);
    rd(4'hA, 8'h00, "R11 rdA"); rd(4'hC, 8'h00, "R11 rdC"); rd(4'hF, 8'h00, "R11 rdF");
    rd(4'hD, 8'h00, "R11 flags untouched");
    chk(pb_out ^ pa_dir, 8'hAA, "R11 ports untouched");

    // R3 latch-only write; R5 rate, flag, one-shot
    wr(4'h6, 8'h20);
    rd(4'h4, 8'h00, "R3 latch write keeps count");
    wr(4'h5, 8'h00);
    rd(4'h4, 8'h20, "R4 loaded count");
    rd(4'h4, 8'h1F, "R5 first step");
    idle(3);
    rd(4'h4, 8'h1B, "R5 rate");
    rd(4'h5, 8'h00, "R5 high byte");
    idle(40);
    rd(4'hD, 8'h40, "R5 t1 flag");
    rd(4'h4, 8'h00, "R7 read returns old");
    rd(4'hD, 8'h00, "R7 read clears t1 flag");
    rd(4'h4, 8'h00, "R5 one-shot stays zero");

    // R3 write 4 loads without starting
    wr(4'h4, 8'h10);
    idle(3);
    rd(4'h4, 8'h10, "R3 loaded not running");
    rd(4'h6, 8'h10, "R3 latch low");

    // R4 restart clears flag
    wr(4'h5, 8'h00);
    idle(20);
    rd(4'hD, 8'h40, "R4 flag set");
    wr(4'h5, 8'h00);
    rd(4'hD, 8'h00, "R4 start clears flag");
    idle(20);
    rd(4'hD, 8'h40, "R4 flag again");

    // R12 set beats clear on the same edge
    wr(4'h4, 8'h03);
    wr(4'hD, 8'h40);
    rd(4'hD, 8'h00, "R8 write-one clears");
    wr(4'h5, 8'h00);
    idle(2);
    wr(4'hD, 8'h40);
    rd(4'hD, 8'h40, "R12 set wins");
    wr(4'hD, 8'h40);
    rd(4'hD, 8'h00, "R8 cleared");

    // R10 request timing
    wr(4'hE, 8'hC0);
    rd(4'hE, 8'hC0, "R9 set bit6");
    wr(4'h5, 8'h00);
    idle(2);
    chk({7'b0, irq_n}, 8'h01, "R10 idle high");
    idle(1);
    chk({7'b0, irq_n}, 8'h01, "R10 one clock lag");
    idle(1);
    chk({7'b0, irq_n}, 8'h00, "R10 asserted");
    rd(4'hD, 8'hC0, "R8 summary bit");
    wr(4'hD, 8'h40);
    rd(4'hD, 8'h00, "R8 cleared with mask");
    chk({7'b0, irq_n}, 8'h01, "R10 released");

    // R9 mask protocol
    wr(4'hE, 8'h40); rd(4'hE, 8'h80, "R9 clear bit6");
    wr(4'hE, 8'hFF); rd(4'hE, 8'hFF, "R9 set all");
    wr(4'hE, 8'h05); rd(4'hE, 8'hFA, "R9 clear 0 and 2");
    wr(4'hE, 8'h7F); rd(4'hE, 8'h80, "R9 clear all");

    // R6 timer 2
    wr(4'h8, 8'h04);
    rd(4'h9, 8'h04, "R6 latch");
    wr(4'hE, 8'hA0);
    wr(4'h9, 8'h00);
    rd(4'h8, 8'h04, "R6 loaded");
    idle(10);
    rd(4'hD, 8'hA0, "R6 t2 flag with mask");
    chk({7'b0, irq_n}, 8'h00, "R10 t2 request");
    rd(4'h8, 8'h00, "R6 stopped at zero");
    rd(4'hD, 8'h00, "R7 read clears t2 flag");
    chk({7'b0, irq_n}, 8'h01, "R10 t2 released");
    wr(4'hE, 8'h20);
    wr(4'h9, 8'h00);
    idle(10);
    rd(4'hD, 8'h20, "R6 flag unmasked");
    wr(4'h9, 8'h01);
    rd(4'hD, 8'h00, "R6 start clears flag");
    idle(300);
    rd(4'hD, 8'h20, "R6 long count");
    wr(4'hD, 8'h00);
    rd(4'hD, 8'h20, "R8 zero write keeps flag");
    wr(4'hD, 8'h20);
    rd(4'hD, 8'h00, "R8 write-one clears t2");
    chk({7'b0, irq_n}, 8'h01, "R10 masked never asserts");

    idle(3);
    if (sbq.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", sbq.size());
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule